// File: doc/BRIEF.md
# DRAM Command Decoder and Bank Tracker

This block watches the control pins of a four-bank DRAM command bus. On every rising clock edge it samples the clock-enable, chip-select, row-strobe, column-strobe and write-enable lines, together with the bank address and the row or column address. It turns that pin pattern into a single command code and keeps, for each bank, an idle or active flag and the row that was opened. It is meant to sit beside a memory controller or a memory model as a protocol monitor and state shadow.

Each decoded command is checked against the bank state that held before the edge. A read or write to a closed bank, an activate to a bank that is already open, a refresh while any row is open, or a mode register write made in a bad state raises a one-cycle illegal flag. A command that is flagged leaves the bank state as it was. When clock-enable is first sampled low, the block reports power-down entry. It reports precharge power-down if every bank is idle and active power-down if any row is open.

All outputs are registered. The command code, the illegal flag, the power-down pulses and the updated bank state for a command sampled at edge k are all visible just after edge k.

Top module: `dram_bank_tracker`

## Requirements
- R1: The block reports the command sampled at each edge on `cmd_o`, just after that edge. The command is found from {ras_ni,cas_ni,we_ni} with cs_ni low and cke_i high, as follows:
  - 011 is activate, code 2.
  - 101 is read, code 3.
  - 100 is write, code 4.
  - 010 is precharge: code 5 when addr_i[8] is low and code 6 when addr_i[8] is high.
  - 001 is refresh, code 7.
  - 000 is a mode register write: code 8 when ba_i[0] is low and code 9 (extended) when ba_i[0] is high.
  - 111 and 110 are no-operation, code 1.
- R2: A legal activate marks bank ba_i active. Bank b is shown as bank_active_o[b], and its row is stored from addr_i[11:0] into open_row_o[12*b +: 12].
- R3: A code 5 precharge closes bank ba_i. A code 6 precharge closes all banks. The stored rows are kept.
- R4: A read or write to a bank that is idle sets illegal_o for exactly the cycle that reports that command.
- R5: An activate to a bank that is already active sets illegal_o, and neither the active flag nor the stored row of that bank changes.
- R6: A refresh while any bank is active sets illegal_o. A refresh while all banks are idle is legal.
- R7: A mode register write (code 8 or 9) sets illegal_o if any bank is active, or if cke_i was low at the previous edge.
- R8: When cs_ni is high, or cke_i is low, the cycle is reported as deselect (code 0) and no bank state changes.
- R9: On an edge where cke_i is low and was high at the previous edge, the block raises a one-cycle pulse: pd_pre_o if all banks were idle, pd_act_o if any bank had a row open. The pulse is not repeated while cke_i stays low.
- R10: While rst_ni is low, every bank is idle, every stored row is zero, and cmd_o, illegal_o, pd_pre_o and pd_act_o are zero. The previous clock-enable level is also taken as low.
- R11: A precharge to a bank that is already idle is legal and does not set illegal_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; pins sampled on rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Clock enable |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| ba_i | input | 2 | Bank address |
| addr_i | input | 12 | Row address / precharge-all select on bit 8 |
| cmd_o | output | 4 | Decoded command code |
| illegal_o | output | 1 | Command illegal for current state |
| bank_active_o | output | 4 | Per-bank active flag |
| open_row_o | output | 48 | Per-bank stored row, 12 bits per bank |
| pd_pre_o | output | 1 | Precharge power-down entry pulse |
| pd_act_o | output | 1 | Active power-down entry pulse |

## Verification
Several rules are checked by the assertions on every cycle:
- A read or write to a closed bank is always flagged.
- An activate to an open bank is flagged and leaves the stored row unchanged.
- A legal activate latches the row into the addressed bank.
- A precharge leaves its target closed.
- Deselect cycles leave the bank flags alone.
- A legal refresh only ever appears with all banks idle.
- The power-down entry pulse lasts one cycle.

Other behaviour can only be shown by the bench's command sequences:
- The exact command code for each pin pattern.
- The mode register rule that depends on the previous clock-enable level.
- The choice between precharge and active power-down after a given history of activates and precharges.
- Precharge-all against single-bank precharge.

// File: rtl/dram_cmd_pkg.sv
package dram_cmd_pkg;
  localparam int unsigned NUM_BANKS = 4;
  localparam int unsigned ROW_W     = 12;
  localparam int unsigned BA_W      = $clog2(NUM_BANKS);
  localparam int unsigned PALL_BIT  = 8;

  typedef enum logic [3:0] {
    CMD_DESEL = 4'd0,
    CMD_NOP   = 4'd1,
    CMD_ACT   = 4'd2,
    CMD_RD    = 4'd3,
    CMD_WR    = 4'd4,
    CMD_PRE   = 4'd5,
    CMD_PREA  = 4'd6,
    CMD_REF   = 4'd7,
    CMD_MRS   = 4'd8,
    CMD_EMRS  = 4'd9
  } cmd_e;
endpackage

// File: rtl/dram_cmd_decode.sv
module dram_cmd_decode
  import dram_cmd_pkg::*;
(
  input  logic cke_i,
  input  logic cs_ni,
  input  logic ras_ni,
  input  logic cas_ni,
  input  logic we_ni,
  input  logic ba0_i,
  input  logic pall_i,
  output cmd_e cmd_o
);
  always_comb begin
    cmd_o = CMD_DESEL;
    if (cke_i && !cs_ni) begin
      case ({ras_ni, cas_ni, we_ni})
        3'b011:  cmd_o = CMD_ACT;
        3'b101:  cmd_o = CMD_RD;
        3'b100:  cmd_o = CMD_WR;
        3'b010:  cmd_o = pall_i ? CMD_PREA : CMD_PRE;
        3'b001:  cmd_o = CMD_REF;
        3'b000:  cmd_o = ba0_i ? CMD_EMRS : CMD_MRS;
        default: cmd_o = CMD_NOP;
      endcase
    end
  end
endmodule

// File: rtl/dram_bank_slot.sv
module dram_bank_slot #(
  parameter int unsigned ROW_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             open_i,
  input  logic             close_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             active_o,
  output logic [ROW_W-1:0] row_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      row_o    <= '0;
    end else if (open_i) begin
      active_o <= 1'b1;
      row_o    <= row_i;
    end else if (close_i) begin
      active_o <= 1'b0;
    end
  end

  AST_OPEN_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    open_i |=> active_o && row_o == $past(row_i)); // R2
  AST_CLOSE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    close_i |=> !active_o); // R3
endmodule

// File: rtl/dram_cmd_check.sv
module dram_cmd_check
  import dram_cmd_pkg::*;
#(
  parameter int unsigned BANKS = 4,
  parameter int unsigned BAW   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cke_i,
  input  cmd_e             cmd_i,
  input  logic [BAW-1:0]   ba_i,
  input  logic [BANKS-1:0] bank_active_i,
  output logic             illegal_o,
  output logic             pd_pre_o,
  output logic             pd_act_o
);
  logic cke_q;
  logic sel_open, any_open, bad;

  assign sel_open = bank_active_i[ba_i];
  assign any_open = |bank_active_i;

  always_comb begin
    case (cmd_i)
      CMD_RD, CMD_WR:    bad = !sel_open;
      CMD_ACT:           bad = sel_open;
      CMD_REF:           bad = any_open;
      CMD_MRS, CMD_EMRS: bad = any_open || !cke_q;
      default:           bad = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cke_q     <= 1'b0;
      illegal_o <= 1'b0;
      pd_pre_o  <= 1'b0;
      pd_act_o  <= 1'b0;
    end else begin
      cke_q     <= cke_i;
      illegal_o <= bad;
      pd_pre_o  <= cke_q && !cke_i && !any_open;
      pd_act_o  <= cke_q && !cke_i && any_open;
    end
  end

  AST_PD_PRE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_pre_o |=> !pd_pre_o); // R9
  AST_PD_ACT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_act_o |=> !pd_act_o); // R9
endmodule

// File: rtl/dram_bank_tracker.sv
module dram_bank_tracker
  import dram_cmd_pkg::*;
#(
  parameter int unsigned BANKS = NUM_BANKS,
  parameter int unsigned RW    = ROW_W,
  parameter int unsigned PBIT  = PALL_BIT,
  localparam int unsigned BAW  = $clog2(BANKS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cke_i,
  input  logic                cs_ni,
  input  logic                ras_ni,
  input  logic                cas_ni,
  input  logic                we_ni,
  input  logic [BAW-1:0]      ba_i,
  input  logic [RW-1:0]       addr_i,
  output logic [3:0]          cmd_o,
  output logic                illegal_o,
  output logic [BANKS-1:0]    bank_active_o,
  output logic [BANKS*RW-1:0] open_row_o,
  output logic                pd_pre_o,
  output logic                pd_act_o
);
  cmd_e cmd_d, cmd_q;

  dram_cmd_decode i_decode (
    .cke_i  (cke_i),
    .cs_ni  (cs_ni),
    .ras_ni (ras_ni),
    .cas_ni (cas_ni),
    .we_ni  (we_ni),
    .ba0_i  (ba_i[0]),
    .pall_i (addr_i[PBIT]),
    .cmd_o  (cmd_d)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic open_b, close_b;
    assign open_b  = (cmd_d == CMD_ACT) && (ba_i == BAW'(b)) && !bank_active_o[b];
    assign close_b = (cmd_d == CMD_PREA) || ((cmd_d == CMD_PRE) && (ba_i == BAW'(b)));
    dram_bank_slot #(.ROW_W(RW)) i_slot (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .open_i   (open_b),
      .close_i  (close_b),
      .row_i    (addr_i),
      .active_o (bank_active_o[b]),
      .row_o    (open_row_o[b*RW +: RW])
    );
  end

  dram_cmd_check #(.BANKS(BANKS), .BAW(BAW)) i_check (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cke_i         (cke_i),
    .cmd_i         (cmd_d),
    .ba_i          (ba_i),
    .bank_active_i (bank_active_o),
    .illegal_o     (illegal_o),
    .pd_pre_o      (pd_pre_o),
    .pd_act_o      (pd_act_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cmd_q <= CMD_DESEL;
    else         cmd_q <= cmd_d;
  end
  assign cmd_o = cmd_q;

  AST_RW_IDLE_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cmd_d == CMD_RD || cmd_d == CMD_WR) && !bank_active_o[ba_i]) |=> illegal_o); // R4
  AST_ACT_BUSY_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_d == CMD_ACT && bank_active_o[ba_i]) |=> illegal_o && $stable(open_row_o)); // R5
  AST_REF_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_REF && !illegal_o) |-> bank_active_o == '0); // R6
  AST_DESEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_DESEL) |-> $stable(bank_active_o)); // R8
endmodule

// File: tb/test_dram_bank_tracker.sv
`timescale 1ns/1ps
module test_dram_bank_tracker;
  localparam int NB = 4;
  localparam int RW = 12;

  logic clk = 1'b0;
  logic rst_ni, cke, cs_n, ras_n, cas_n, we_n;
  logic [1:0] ba;
  logic [RW-1:0] addr;
  logic [3:0] cmd_o;
  logic illegal_o, pd_pre_o, pd_act_o;
  logic [NB-1:0] act_o;
  logic [NB*RW-1:0] rows_o;

  always #4 clk = ~clk;

  dram_bank_tracker i_dram_bank_tracker (
    .clk_i(clk), .rst_ni(rst_ni), .cke_i(cke), .cs_ni(cs_n), .ras_ni(ras_n),
    .cas_ni(cas_n), .we_ni(we_n), .ba_i(ba), .addr_i(addr), .cmd_o(cmd_o),
    .illegal_o(illegal_o), .bank_active_o(act_o), .open_row_o(rows_o),
    .pd_pre_o(pd_pre_o), .pd_act_o(pd_act_o)
  );

  typedef struct {
    logic [3:0]       cmd;
    logic             ill;
    logic [NB-1:0]    act;
    logic [NB*RW-1:0] rows;
    logic             pdp;
    logic             pda;
    string            tag;
  } exp_t;

  exp_t sb[$];
  exp_t got;
  int checks = 0;
  int fails  = 0;
  logic [NB-1:0] m_act;
  logic [NB*RW-1:0] m_rows;
  logic m_cke;

  always @(negedge clk) begin
    if (sb.size() > 0) begin
      got = sb.pop_front();
      checks++;
      if (cmd_o !== got.cmd || illegal_o !== got.ill || act_o !== got.act ||
          rows_o !== got.rows || pd_pre_o !== got.pdp || pd_act_o !== got.pda) begin
        fails++;
        $display("FAIL %s: got cmd=%0d ill=%b act=%b rows=%h pdp=%b pda=%b exp cmd=%0d ill=%b act=%b rows=%h pdp=%b pda=%b",
                 got.tag, cmd_o, illegal_o, act_o, rows_o, pd_pre_o, pd_act_o,
                 got.cmd, got.ill, got.act, got.rows, got.pdp, got.pda);
      end
    end
  end

  task automatic step(input logic k, input logic c, input logic r, input logic ca,
                      input logic w, input logic [1:0] b, input logic [RW-1:0] a,
                      input string tag);
    exp_t e;
    logic any;
    cke = k; cs_n = c; ras_n = r; cas_n = ca; we_n = w; ba = b; addr = a;
    any = |m_act;
    if (!k || c) e.cmd = 4'd0;
    else case ({r, ca, w})
      3'b011: e.cmd = 4'd2;
      3'b101: e.cmd = 4'd3;
      3'b100: e.cmd = 4'd4;
      3'b010: e.cmd = a[8] ? 4'd6 : 4'd5;
      3'b001: e.cmd = 4'd7;
      3'b000: e.cmd = b[0] ? 4'd9 : 4'd8;
      default: e.cmd = 4'd1;
    endcase
    case (e.cmd)
      4'd3, 4'd4: e.ill = !m_act[b];
      4'd2:       e.ill = m_act[b];
      4'd7:       e.ill = any;
      4'd8, 4'd9: e.ill = any || !m_cke;
      default:    e.ill = 1'b0;
    endcase
    e.pdp = m_cke && !k && !any;
    e.pda = m_cke && !k && any;
    if (e.cmd == 4'd2 && !m_act[b]) begin
      m_act[b] = 1'b1;
      m_rows[b*RW +: RW] = a;
    end
    if (e.cmd == 4'd5) m_act[b] = 1'b0;
    if (e.cmd == 4'd6) m_act = '0;
    m_cke = k;
    e.act = m_act; e.rows = m_rows; e.tag = tag;
    @(posedge clk);
    sb.push_back(e);
    @(negedge clk);
  endtask

  initial begin
    #800000;
    checks++; fails++;
    $display("FAIL watchdog: run did not complete");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; cke = 1'b0; cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
    ba = '0; addr = '0;
    m_act = '0; m_rows = '0; m_cke = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if (cmd_o !== 4'd0 || illegal_o !== 1'b0 || act_o !== '0 || rows_o !== '0 ||
        pd_pre_o !== 1'b0 || pd_act_o !== 1'b0) begin
      fails++;
      $display("FAIL R10 reset: got cmd=%0d ill=%b act=%b rows=%h exp all zero",
               cmd_o, illegal_o, act_o, rows_o);
    end
    rst_ni = 1'b1;
    @(negedge clk);
    //   cke cs ras cas we ba addr
    step(1, 0, 1, 1, 1, 0, 12'h000, "R1 nop");
    step(1, 0, 0, 0, 0, 1, 12'h040, "R7 emrs legal");
    step(1, 0, 0, 0, 0, 0, 12'h032, "R7 mrs legal");
    step(1, 0, 0, 0, 1, 0, 12'h000, "R6 refresh idle legal");
    step(1, 0, 1, 0, 1, 1, 12'h010, "R4 read idle bank");
    step(1, 0, 1, 0, 0, 2, 12'h020, "R4 write idle bank");
    step(1, 0, 0, 1, 1, 1, 12'hABC, "R2 activate bank1");
    step(1, 0, 0, 1, 1, 3, 12'h123, "R2 activate bank3");
    step(1, 0, 0, 1, 1, 1, 12'h555, "R5 activate open bank");
    step(1, 0, 1, 0, 1, 1, 12'h004, "R1 read open bank");
    step(1, 0, 1, 0, 0, 3, 12'h008, "R1 write open bank");
    step(1, 0, 0, 0, 1, 0, 12'h000, "R6 refresh with open row");
    step(1, 0, 0, 0, 0, 1, 12'h000, "R7 emrs with open row");
    step(1, 1, 0, 1, 1, 0, 12'hFFF, "R8 deselect no change");
    step(0, 0, 0, 1, 1, 2, 12'h777, "R9 active power-down");
    step(0, 0, 0, 1, 1, 2, 12'h777, "R8 cke low ignored");
    step(1, 0, 1, 1, 1, 0, 12'h000, "R1 nop exit");
    step(1, 0, 1, 1, 0, 0, 12'h000, "R1 code 110 nop");
    step(1, 0, 0, 1, 0, 1, 12'h000, "R3 precharge bank1");
    step(1, 0, 0, 1, 0, 0, 12'h000, "R11 precharge idle bank");
    step(1, 0, 0, 1, 1, 2, 12'h2A5, "R2 activate bank2");
    step(1, 0, 0, 1, 0, 0, 12'h100, "R3 precharge all");
    step(0, 0, 1, 1, 1, 0, 12'h000, "R9 precharge power-down");
    step(1, 0, 0, 0, 0, 1, 12'h000, "R7 emrs after cke low");
    step(1, 0, 0, 0, 0, 1, 12'h000, "R7 emrs cke stable");
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule